// File: doc/BRIEF.md
# Overlap-Time Gate Signal Generator

This block sits between a modulator and the six gate drivers of a three-phase current-source bridge. The modulator gives one ideal on/off command per switch. The block passes every turn-on straight through. It holds every turn-off back by a programmable number of clock cycles, so that during a commutation the outgoing and the incoming switch conduct together. The inductor current in the DC link therefore always has a path. Two switches conducting at once is a normal state for this bridge. A state in which no upper switch, or no lower switch, is on must never be produced by the overlap logic.

Each switch has its own channel with a countdown. The countdown starts when that switch's command is released. While it runs, the gate stays on. It ends either when the count is used up or when the command comes back. Reset puts the bridge into a null vector: the upper and lower switch of one chosen leg are both on. A combinational monitor flags any cycle in which one arm of the bridge has no conducting switch.

Bit layout: bit `i` (i = 0..2) drives the upper switch of leg i, and bit `3+i` drives the lower switch of leg i.

Top module: `csi_ovl_gate`

## Requirements
- R1: A command bit that is sampled high at a clock edge makes the matching gate bit high after that same edge. Turn-on therefore has one cycle of latency and no added delay.
- R2: Let L be the overlap length, with L > 0. If a command bit was high and is first sampled low at edge k, its gate bit stays high after edges k .. k+L-1 and is low from edge k+L onward.
- R3: With an overlap length of 0, each gate bit equals its command bit delayed by one cycle.
- R4: If a command re-asserts while its turn-off is still pending, the pending turn-off is cancelled and the gate stays high without a gap. The next release starts a fresh countdown of the full length.
- R5: The overlap length is captured on the edge where the release is seen. Changing `ovl_len_i` while a countdown runs does not alter that countdown.
- R6: While reset is active (synchronous, active low), the gates show the null vector of leg RESET_LEG, which is 6'b001001 by default. After reset these two bits count as commanded, so if the commands are low they hold for L more cycles.
- R7: `open_flag_o` is high in exactly those cycles where `gate_o[2:0]` is all zero or `gate_o[5:3]` is all zero. It follows `gate_o` in the same cycle.
- R8: The six channels are independent. A command change on one bit never changes another bit's gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 6 | Ideal gate commands from the modulator; bits 2:0 upper, bits 5:3 lower |
| ovl_len_i | input | 16 | Overlap length in clock cycles |
| gate_o | output | 6 | Gate drive with the overlap inserted |
| open_flag_o | output | 1 | High when one arm has no conducting switch |

## Verification
Every gate result is due one edge after the command is sampled. A turn-off is due exactly L edges after the first edge that sees the command low, and the open flag is due in the same cycle as the gate vector it describes. The bench keeps an integer model that records, per channel, the edge index at which the gate must drop. It compares `gate_o` and `open_flag_o` against that model at every falling clock edge, halfway between the edge that updates the outputs and the next one. Directed phases cover the reset pattern, zero and nonzero overlap lengths, re-assertion inside the window and length changes mid-count. A random phase then drives the channels independently.

// File: rtl/csi_ovl_pkg.sv
// Package: shared types and helpers for the overlap-time gate generator.
// Assumes: bit i is the upper switch of leg i, bit NUM_LEGS+i the lower one.
package csi_ovl_pkg;

    // Per-channel conduction state.
    typedef enum logic [1:0] {
        CH_OFF  = 2'b00,  // gate off, no pending turn-off
        CH_ON   = 2'b01,  // command was high at the last edge
        CH_HOLD = 2'b10   // command released, overlap countdown running
    } ch_state_t;

    // Gate vector of the null vector formed by one leg.
    function automatic logic [31:0] null_vector(input int legs, input int leg);
        logic [31:0] v;
        v = '0;
        v[leg]        = 1'b1;
        v[legs + leg] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/csi_ovl_channel.sv
// Module: one switch channel. It passes turn-on after one cycle and
// stretches turn-off by the overlap length captured at release.
// Assumes: synchronous active-low reset; len_i is sampled only at release.
module csi_ovl_channel
    import csi_ovl_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter bit RESET_ON = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             gate_o
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    ch_state_t        state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;

    // Next-state logic: a high command wins, a release loads the count.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cmd_i) begin
            state_d = CH_ON;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                CH_ON: begin
                    if (len_i == '0) begin
                        state_d = CH_OFF;
                    end else begin
                        state_d = CH_HOLD;
                        cnt_d   = len_i;
                    end
                end
                CH_HOLD: begin
                    if (cnt_q <= ONE) begin
                        state_d = CH_OFF;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: begin
                    state_d = CH_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register; reset puts the channel into its safe pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_ON ? CH_ON : CH_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Gate drive: on in every state except OFF.
    always_comb gate_o = (state_q != CH_OFF);

endmodule

// File: rtl/csi_ovl_arm_monitor.sv
// Module: flags a cycle in which either bridge arm has no switch on.
// Assumes: upper switches occupy the low half of the gate vector.
module csi_ovl_arm_monitor #(
    parameter int NUM_LEGS   = 3,
    parameter bit EN_MONITOR = 1'b1
) (
    input  logic [2*NUM_LEGS-1:0] gate_i,
    output logic                  open_o
);

    generate
        if (EN_MONITOR) begin : g_mon
            logic upper_any, lower_any;
            // Arm occupancy: any conducting switch per arm.
            always_comb begin
                upper_any = |gate_i[NUM_LEGS-1:0];
                lower_any = |gate_i[2*NUM_LEGS-1:NUM_LEGS];
                open_o    = !upper_any || !lower_any;
            end
        end else begin : g_nomon
            // Monitor left out: flag tied low.
            always_comb open_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/csi_ovl_gate.sv
// Module: top of the overlap-time gate generator. It has one channel per
// switch and a combinational arm monitor on the resulting gate vector.
// Assumes: commands come from a modulator in the clk domain.
module csi_ovl_gate
    import csi_ovl_pkg::*;
#(
    parameter int NUM_LEGS   = 3,
    parameter int LEN_W      = 16,
    parameter int RESET_LEG  = 0,
    parameter bit EN_MONITOR = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*NUM_LEGS-1:0] cmd_i,
    input  logic [LEN_W-1:0]      ovl_len_i,
    output logic [2*NUM_LEGS-1:0] gate_o,
    output logic                  open_flag_o
);

    localparam int NSW = 2 * NUM_LEGS;
    localparam logic [31:0] SAFE32 = null_vector(NUM_LEGS, RESET_LEG);
    localparam logic [NSW-1:0] SAFE = SAFE32[NSW-1:0];

    logic [NSW-1:0] gate_w;

    // One channel per switch; the reset leg starts conducting.
    generate
        for (genvar i = 0; i < NSW; i++) begin : g_ch
            csi_ovl_channel #(
                .LEN_W   (LEN_W),
                .RESET_ON(SAFE[i])
            ) u_ch (
                .clk   (clk),
                .rst_n (rst_n),
                .cmd_i (cmd_i[i]),
                .len_i (ovl_len_i),
                .gate_o(gate_w[i])
            );
        end
    endgenerate

    // Gate drive to the output.
    always_comb gate_o = gate_w;

    csi_ovl_arm_monitor #(
        .NUM_LEGS  (NUM_LEGS),
        .EN_MONITOR(EN_MONITOR)
    ) u_mon (
        .gate_i(gate_w),
        .open_o(open_flag_o)
    );

endmodule

// File: rtl/csi_ovl_gate_chk.sv
// Module: property checker for csi_ovl_gate, attached with bind.
module csi_ovl_gate_chk
    import csi_ovl_pkg::*;
#(
    parameter int NUM_LEGS  = 3,
    parameter int LEN_W     = 16,
    parameter int RESET_LEG = 0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2*NUM_LEGS-1:0] cmd_i,
    input logic [LEN_W-1:0]      ovl_len_i,
    input logic [2*NUM_LEGS-1:0] gate_o
);

    localparam int NSW = 2 * NUM_LEGS;
    localparam logic [31:0] SAFE32 = null_vector(NUM_LEGS, RESET_LEG);
    localparam logic [NSW-1:0] SAFE = SAFE32[NSW-1:0];

    logic [NSW-1:0] prev_cmd;
    logic [NSW-1:0] rel;
    logic           was_rst;

    // Commands seen at the last edge; reset counts as the null vector.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_cmd <= SAFE;
        else        prev_cmd <= cmd_i;
    end

    always_comb rel = prev_cmd & ~cmd_i;

    // R6: pattern visible on the cycle after reset ends.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
        if (rst_n && was_rst === 1'b1) begin
            // R6
            reset_null_chk: assert (gate_o == SAFE)
                else $error("gate %b after reset", gate_o);
        end
    end

    // R1
    turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |cmd_i |=> ((gate_o & $past(cmd_i)) == $past(cmd_i)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel && ovl_len_i != '0) |=> ((gate_o & $past(rel)) == $past(rel)));

    // R3
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel && ovl_len_i == '0) |=> ((gate_o & $past(rel)) == '0));

    // R8
    no_spurious_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(~gate_o & ~cmd_i) |=> ((gate_o & $past(~gate_o & ~cmd_i)) == '0));

endmodule

bind csi_ovl_gate csi_ovl_gate_chk #(
    .NUM_LEGS (NUM_LEGS),
    .LEN_W    (LEN_W),
    .RESET_LEG(RESET_LEG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd_i),
    .ovl_len_i(ovl_len_i),
    .gate_o   (gate_o)
);

// File: tb/tb_csi_ovl_gate.sv
module tb_csi_ovl_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cmd_i = 6'b0;
    logic [15:0] ovl_len_i = 16'd0;
    logic [5:0]  gate_o;
    logic        open_flag_o;

    int checks = 0;
    int errors = 0;
    int edge_n = 0;
    bit started = 0;
    string req = "R6";

    // Reference model: per channel, edge index at which the gate must drop.
    int  drop_at [6];
    bit  armed   [6];
    bit  exp_g   [6];

    always #2 clk = ~clk;  // 250 MHz

    csi_ovl_gate dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .ovl_len_i(ovl_len_i),
        .gate_o(gate_o), .open_flag_o(open_flag_o)
    );

    always @(posedge clk) begin
        edge_n++;
        started = 1;
        for (int i = 0; i < 6; i++) begin
            if (!rst_n) begin
                armed[i]   = (i == 0 || i == 3);
                exp_g[i]   = armed[i];
                drop_at[i] = -1;
            end else if (cmd_i[i]) begin
                armed[i] = 1;
                exp_g[i] = 1;
            end else begin
                if (armed[i]) begin
                    drop_at[i] = edge_n + int'(ovl_len_i);
                    armed[i]   = 0;
                end
                exp_g[i] = (edge_n < drop_at[i]);
            end
        end
    end

    function automatic logic [5:0] exp_vec();
        logic [5:0] v;
        for (int i = 0; i < 6; i++) v[i] = exp_g[i];
        return v;
    endfunction

    // Compare on every falling edge, away from the updating edge.
    always @(negedge clk) begin
        if (started) begin
            logic [5:0] ev;
            logic       ef;
            ev = exp_vec();
            ef = (ev[2:0] == 3'b0) || (ev[5:3] == 3'b0);
            checks++;
            if (gate_o !== ev) begin
                errors++;
                $display("FAIL %s gate edge %0d actual %b expected %b", req, edge_n, gate_o, ev);
            end
            checks++;
            if (open_flag_o !== ef) begin
                errors++;
                $display("FAIL R7 open flag edge %0d actual %b expected %b", edge_n, open_flag_o, ef);
            end
        end
    end

    task automatic drive(input logic [5:0] c, input int n);
        @(negedge clk);
        cmd_i = c;
        repeat (n - 1) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R6: reset pattern, then hold for L cycles with commands low.
        ovl_len_i = 16'd4;
        repeat (3) @(negedge clk);
        checks++;
        if (gate_o !== 6'b001001) begin
            errors++;
            $display("FAIL R6 reset actual %b expected %b", gate_o, 6'b001001);
        end
        rst_n = 1'b1;
        drive(6'b000000, 8);
        // R7 flagged while the bridge is open.
        checks++;
        if (open_flag_o !== 1'b1) begin
            errors++;
            $display("FAIL R7 open actual %b expected 1", open_flag_o);
        end
        // R1, R2: commutations with L=3.
        req = "R2";
        ovl_len_i = 16'd3;
        drive(6'b001001, 4);
        drive(6'b100001, 5);
        drive(6'b100010, 5);
        drive(6'b010010, 5);
        req = "R1";
        drive(6'b011011, 2);
        drive(6'b001001, 6);
        // R2 with L=1.
        req = "R2";
        ovl_len_i = 16'd1;
        drive(6'b100100, 3);
        drive(6'b010100, 3);
        // R3: zero length passes commands.
        req = "R3";
        ovl_len_i = 16'd0;
        drive(6'b001100, 3);
        drive(6'b010001, 1);
        drive(6'b100010, 2);
        drive(6'b001001, 3);
        // R4: re-assert inside the window.
        req = "R4";
        ovl_len_i = 16'd5;
        drive(6'b000000, 2);
        drive(6'b001001, 1);
        drive(6'b000000, 3);
        drive(6'b001001, 2);
        drive(6'b000000, 8);
        // R5: length change mid count.
        req = "R5";
        drive(6'b100100, 2);
        ovl_len_i = 16'd6;
        drive(6'b000000, 2);
        ovl_len_i = 16'd1;
        drive(6'b000000, 9);
        // R8: independent random channels.
        req = "R8";
        ovl_len_i = 16'd2;
        for (int k = 0; k < 300; k++) begin
            drive(6'($urandom), 1 + int'($urandom % 4));
            if (k % 50 == 0) ovl_len_i = 16'($urandom % 5);
        end
        drive(6'b001001, 3);
        drive(6'b000000, 10);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule